// File: doc/BRIEF.md
# Interrupt status and masking unit

This block keeps the 32-bit interrupt status of a memory-card host controller in two layers. Internal event sources raise bits in a hidden pending layer. Software sees a visible layer. The two layers are merged only when software reads the status register. That read also empties the pending layer. A write to the status register clears visible bits by write-one-to-clear, and it leaves the pending layer alone.

Two enable registers shape the result. The status-enable mask filters the events that may enter the pending layer. Both masks together gate the single interrupt line. Each time an event is posted, bit 15 (error summary) of the pending layer is recomputed from the upper half-word.

Bit meanings used by the event sources:

| Bit | Meaning |
|---|---|
| 0 | command complete |
| 1 | transfer complete |
| 4 | write-buffer ready |
| 5 | read-buffer ready |
| 16 | command timeout |
| 28 | card error |

Top module: `irq_status_unit`

## Requirements
- R1: `irq_o` is high exactly when `(visible | pending) & status_enable & signal_enable` is nonzero, evaluated on the registered state.
- R2: A status read (`stat_rd_i`) returns `visible | pending` on `stat_rdata_o` in that cycle. At the next edge it ORs the pending bits into the visible layer and clears the pending layer.
- R3: A status write (`stat_wr_i`) clears visible bits where `wdata_i & 0x317F0237` has ones. It leaves the pending layer unchanged, so bit 15, for example, is never cleared by a write.
- R4: When `evt_i` is nonzero, the new pending value is `(pending | evt_i) & status_enable`. Bit 15 of the result is then set if any of bits 31:16 of it are set.
- R5: The status-enable and signal-enable registers each store `wdata_i & 0x317F0337` when their write strobe is high. They read back on `stat_en_o` and `sig_en_o`.
- R6: On a status-enable write, bit 9 takes the written value only when `ovr_wr_en_i` is high. Otherwise bit 9 keeps its previous value.
- R7: When a read and an event occur in the same cycle, the read drains the old pending bits into the visible layer. The new event bits remain in the pending layer.
- R8: When a status write and an event hit the same bit in one cycle, the event still lands in the pending layer.
- R9: After `rst_ni` is low, every register is zero: `stat_rdata_o`, `stat_en_o`, `sig_en_o` and `irq_o` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| evt_i | input | 32 | event bits posted to the pending layer |
| stat_rd_i | input | 1 | status register read strobe |
| stat_wr_i | input | 1 | status register write strobe (write-one-to-clear) |
| stat_en_wr_i | input | 1 | status-enable register write strobe |
| sig_en_wr_i | input | 1 | signal-enable register write strobe |
| ovr_wr_en_i | input | 1 | permits writing bit 9 of the status-enable register |
| wdata_i | input | 32 | write data shared by all writes |
| stat_rdata_o | output | 32 | merged status, valid on a read |
| stat_en_o | output | 32 | status-enable register |
| sig_en_o | output | 32 | signal-enable register |
| irq_o | output | 1 | interrupt line |

## Verification
The hardest situation to bring about is a collision in one cycle: a read, a write-one-to-clear and an event all touching the same bits while the masks change. In that cycle the order of merge, clear and post decides the result. The stimulus first walks directed collisions: read with event, clear with event, and event with a status-enable write. A long pseudo-random phase then drives all strobes at once with dense events and sparse mask rewrites. A behavioural model in the bench is compared on every clock.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  parameter int unsigned STAT_W = 32;
  parameter int unsigned ERR_LO = 16;   // first bit of the error half
  parameter int unsigned SUM_BIT = 15;  // error summary
  parameter int unsigned GATED_BIT = 9; // enable bit needing the override
  parameter logic [STAT_W-1:0] CLR_MASK = 32'h317F_0237;
  parameter logic [STAT_W-1:0] EN_MASK  = 32'h317F_0337;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/irq_pending_layer.sv
module irq_pending_layer
  import irq_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t evt_i,
  input  logic  flush_i,
  input  stat_t stat_en_i,
  output stat_t pend_o
);
  stat_t pend_q, pend_d;

  // flush first, then post: new events survive a draining read
  always_comb begin
    pend_d = flush_i ? '0 : pend_q;
    if (|evt_i) begin
      pend_d = (pend_d | evt_i) & stat_en_i;
      pend_d[SUM_BIT] = |pend_d[STAT_W-1:ERR_LO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_visible_layer.sv
module irq_visible_layer
  import irq_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  stat_t clr_data_i,
  input  logic  merge_i,
  input  stat_t merge_data_i,
  output stat_t vis_o
);
  stat_t vis_q, clr_bits, add_bits;

  assign clr_bits = clr_i   ? (clr_data_i & CLR_MASK) : '0;
  assign add_bits = merge_i ? merge_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vis_q <= '0;
    else         vis_q <= (vis_q & ~clr_bits) | add_bits;
  end

  assign vis_o = vis_q;
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t wdata_i,
  input  logic  stat_en_wr_i,
  input  logic  sig_en_wr_i,
  input  logic  ovr_wr_en_i,
  output stat_t stat_en_o,
  output stat_t sig_en_o
);
  stat_t stat_en_q, sig_en_q, stat_en_d;

  // per-bit write select; the gated bit also needs the override
  for (genvar b = 0; b < STAT_W; b++) begin : g_sen
    if (b == GATED_BIT) begin : g_gated
      assign stat_en_d[b] = (stat_en_wr_i && ovr_wr_en_i) ? (wdata_i[b] & EN_MASK[b])
                                                          : stat_en_q[b];
    end else begin : g_plain
      assign stat_en_d[b] = stat_en_wr_i ? (wdata_i[b] & EN_MASK[b]) : stat_en_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_en_q <= '0;
      sig_en_q  <= '0;
    end else begin
      stat_en_q <= stat_en_d;
      if (sig_en_wr_i) sig_en_q <= wdata_i & EN_MASK;
    end
  end

  assign stat_en_o = stat_en_q;
  assign sig_en_o  = sig_en_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic              stat_en_wr_i,
  input  logic              sig_en_wr_i,
  input  logic              ovr_wr_en_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_rdata_o,
  output logic [STAT_W-1:0] stat_en_o,
  output logic [STAT_W-1:0] sig_en_o,
  output logic              irq_o
);
  stat_t pend_q, vis_q, sen_q, gen_q;

  irq_pending_layer u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .flush_i   (stat_rd_i),
    .stat_en_i (sen_q),
    .pend_o    (pend_q)
  );

  irq_visible_layer u_vis (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (stat_wr_i),
    .clr_data_i   (wdata_i),
    .merge_i      (stat_rd_i),
    .merge_data_i (pend_q),
    .vis_o        (vis_q)
  );

  irq_enable_regs u_en (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdata_i      (wdata_i),
    .stat_en_wr_i (stat_en_wr_i),
    .sig_en_wr_i  (sig_en_wr_i),
    .ovr_wr_en_i  (ovr_wr_en_i),
    .stat_en_o    (sen_q),
    .sig_en_o     (gen_q)
  );

  assign stat_rdata_o = vis_q | pend_q;
  assign stat_en_o    = sen_q;
  assign sig_en_o     = gen_q;
  assign irq_o        = |(stat_rdata_o & sen_q & gen_q);
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_stat_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input stat_t evt_i,
  input logic  stat_rd_i,
  input logic  stat_wr_i,
  input logic  stat_en_wr_i,
  input logic  ovr_wr_en_i,
  input stat_t stat_rdata_o,
  input stat_t stat_en_o,
  input stat_t sig_en_o,
  input logic  irq_o,
  input stat_t pend_q,
  input stat_t vis_q
);
  assert_irq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_rdata_o & stat_en_o & sig_en_o) != '0));

  assert_flush_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && evt_i == '0) |=> pend_q == '0);

  assert_merge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> ((vis_q & $past(pend_q)) == $past(pend_q)));

  assert_keep_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !stat_rd_i && evt_i == '0) |=> pend_q == $past(pend_q));

  assert_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[SUM_BIT] == (|pend_q[STAT_W-1:ERR_LO]));

  assert_en_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_en_o | sig_en_o) & ~EN_MASK) == '0);

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_en_wr_i && !ovr_wr_en_i) |=> stat_en_o[GATED_BIT] == $past(stat_en_o[GATED_BIT]));

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && evt_i != '0) |=>
      ((pend_q & $past(evt_i & stat_en_o)) == $past(evt_i & stat_en_o)));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_i        (evt_i),
  .stat_rd_i    (stat_rd_i),
  .stat_wr_i    (stat_wr_i),
  .stat_en_wr_i (stat_en_wr_i),
  .ovr_wr_en_i  (ovr_wr_en_i),
  .stat_rdata_o (stat_rdata_o),
  .stat_en_o    (stat_en_o),
  .sig_en_o     (sig_en_o),
  .irq_o        (irq_o),
  .pend_q       (pend_q),
  .vis_q        (vis_q)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, sen_wr = 1'b0, gen_wr = 1'b0, ovr = 1'b0;
  logic [31:0] rdata, sen, gen;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_vis = '0, m_pend = '0, m_sen = '0, m_gen = '0;

  always #5 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .evt_i        (evt),
    .stat_rd_i    (rd),
    .stat_wr_i    (wr),
    .stat_en_wr_i (sen_wr),
    .sig_en_wr_i  (gen_wr),
    .ovr_wr_en_i  (ovr),
    .wdata_i      (wdata),
    .stat_rdata_o (rdata),
    .stat_en_o    (sen),
    .sig_en_o     (gen),
    .irq_o        (irq)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // drive one cycle, compare outputs against the model, then advance the model
  task automatic step(string tag, bit i_rd, bit i_wr, bit i_sen, bit i_gen, bit i_ovr,
                      logic [31:0] i_wd, logic [31:0] i_evt);
    logic [31:0] np, nv, ns;
    @(negedge clk);
    rd = i_rd; wr = i_wr; sen_wr = i_sen; gen_wr = i_gen; ovr = i_ovr;
    wdata = i_wd; evt = i_evt;
    #1;
    chk({tag, "/R2"}, "rdata", rdata, m_vis | m_pend);
    chk({tag, "/R1"}, "irq", {31'd0, irq}, {31'd0, ((m_vis | m_pend) & m_sen & m_gen) != 0});
    chk({tag, "/R5"}, "stat_en", sen, m_sen);
    chk({tag, "/R5"}, "sig_en", gen, m_gen);
    // pending: drain on read, then post
    np = i_rd ? 32'd0 : m_pend;
    if (i_evt != 0) begin
      np = (np | i_evt) & m_sen;
      if (np[31:16] != 0) np = np | 32'h0000_8000;
    end
    nv = m_vis;
    if (i_wr) nv = nv & ~(i_wd & 32'h317F_0237);
    if (i_rd) nv = nv | m_pend;
    ns = m_sen;
    if (i_sen) begin
      ns = i_wd & 32'h317F_0337;
      if (!i_ovr) ns[9] = m_sen[9];
    end
    if (i_gen) m_gen = i_wd & 32'h317F_0337;
    m_pend = np; m_vis = nv; m_sen = ns;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 32'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #2;
    chk("R9", "reset rdata", rdata, 32'd0);
    chk("R9", "reset irq", {31'd0, irq}, 32'd0);
    chk("R9", "reset stat_en", sen, 32'd0);
    chk("R9", "reset sig_en", gen, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R9");

    // R5/R6: enables, bit 9 blocked then allowed
    step("R6", 0, 0, 1, 1, 0, 32'hFFFF_FFFF, 32'd0);
    idle("R6");
    chk("R6", "bit9 held", sen, 32'h317F_0137);
    step("R6", 0, 0, 1, 0, 1, 32'hFFFF_FFFF, 32'd0);
    idle("R6");
    chk("R6", "bit9 written", sen, 32'h317F_0337);

    // R4: command complete, then command timeout raises summary
    step("R4", 0, 0, 0, 0, 0, 32'd0, 32'h0000_0001);
    idle("R4");
    chk("R4", "cmd done pending", rdata, 32'h0000_0001);
    chk("R1", "irq on", {31'd0, irq}, 32'd1);
    step("R4", 0, 0, 0, 0, 0, 32'd0, 32'h0001_0000);
    idle("R4");
    chk("R4", "timeout summary", rdata, 32'h0001_8001);

    // R3/R8: clear with nothing visible leaves pending; clear+event same bit
    step("R3", 0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'd0);
    idle("R3");
    chk("R3", "pending kept", rdata, 32'h0001_8001);
    step("R8", 0, 1, 0, 0, 0, 32'h0000_0002, 32'h0000_0002);
    idle("R8");
    chk("R8", "set wins", rdata, 32'h0001_8003);

    // R2: read merges; then clear leaves bit 15 (not clearable)
    step("R2", 1, 0, 0, 0, 0, 32'd0, 32'd0);
    idle("R2");
    chk("R2", "merged", rdata, 32'h0001_8003);
    step("R3", 0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'd0);
    idle("R3");
    chk("R3", "bit15 sticks", rdata, 32'h0000_8000);

    // R7: read and event in one cycle
    step("R7", 0, 0, 0, 0, 0, 32'd0, 32'h0000_0010);
    step("R7", 1, 0, 0, 0, 0, 32'd0, 32'h1000_0020);
    idle("R7");
    chk("R7", "new event pending", rdata, 32'h1000_8030);
    step("R7", 1, 0, 0, 0, 0, 32'd0, 32'd0);
    idle("R7");

    // R1: signal enable off silences the line
    step("R1", 0, 0, 0, 1, 0, 32'd0, 32'd0);
    idle("R1");
    chk("R1", "irq masked", {31'd0, irq}, 32'd0);

    // R4: status enable blocks new events
    step("R4", 0, 1, 1, 1, 1, 32'hFFFF_FFFF, 32'd0);
    step("R4", 0, 0, 1, 0, 1, 32'h0000_0001, 32'd0);
    step("R4", 0, 0, 0, 0, 0, 32'd0, 32'h0001_0012);
    idle("R4");
    chk("R4", "masked events", rdata, 32'h0000_8000);

    // pseudo-random collisions
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] e, w;
      e = ($urandom % 3 == 0) ? $urandom : 32'd0;
      w = $urandom;
      step("RND", ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 16) == 0,
           ($urandom % 16) == 0, $urandom % 2, w, e);
    end
    idle("RND");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule